// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timer

This block produces three center-aligned pulse-width reference signals that share one programmable switching period. A simple strobed write port loads a 12-bit period value and three 12-bit per-channel on-time values. A free-running counter steps through the period one system clock at a time. A one-clock sync pulse marks the first clock of every cycle. Each channel drives a raw on/off signal whose on-interval sits symmetrically about the middle of the cycle. It also reports the on-time that is actually in force after limiting.

Duty writes go into shadow registers. A new set of three on-times is committed only after all three channel registers have been written since the previous commit. The commit point lies a fixed lead of four clocks before the end of the cycle. The edge positions for the next cycle are computed in those last clocks and made active at the cycle boundary. A set that is completed too late is not dropped: it waits one more cycle. Complementary drive, deadtime, minimum-pulse removal and emergency shutdown belong to a downstream output stage.

Top module: `pwm3_center_timer`

## Requirements
- R1: During and after a synchronous active-high reset, every channel output is off and every reported on-time is 0. The sync output is high in the first clock after reset. The effective period is MIN_PERIOD (8) clocks.
- R2: The cycle length in clocks equals the stored period value, with values below MIN_PERIOD (8) treated as 8. A period write takes effect at the same cycle boundary as a duty set written in the same window.
- R3: A write strobe with selector 0 loads the period register, and selectors 1, 2 and 3 load the duty registers of channels A, B and C. The data field is 12 bits wide.
- R4: Within a cycle of P clocks, with offset k counted from 0 at the sync clock, a channel with effective on-time E is on exactly when floor((P−E)/2) ≤ k < floor((P−E)/2)+E.
- R5: The effective on-time E is min(duty, P) and appears on the channel's on-time output. A duty of 0 keeps the channel off for the whole cycle. A duty of P or larger keeps it on for the whole cycle.
- R6: Writing only some of the three duty registers changes no output. The new values take effect only once all three have been written.
- R7: If the last write of a complete set is sampled at offset k ≤ P−5 of a cycle, the set is active from the next cycle. If it is sampled at k ≥ P−4, the set is held over and becomes active one cycle later.
- R8: The sync output is high for exactly one clock per cycle. The reported on-times change only in the clock in which sync is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selector: 0 period, 1 A, 2 B, 3 C |
| wr_data | input | 12 | Write data |
| sync_o | output | 1 | One-clock pulse at each cycle start |
| ch_on_o | output | 3 | Raw center-aligned on signals, bit 0 = A |
| ch_ontime_o | output | 36 | Effective on-times, 12 bits per channel, A in the low bits |

## Verification
A wrong counter or period value shows at once as a sync pulse that arrives early or late, so every cycle that is watched from sync to sync exposes it. A faulty edge computation or limit shows within the first cycle after the commit, as an on-interval that is shifted, too wide or not centered. A fault in the pending-write tracking or in the commit window shows one cycle early or late, as a switch to new on-times. The sweeps therefore check every clock of whole cycles, and they place writes on both sides of the window edge.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
   typedef enum logic [1:0] {
      SEL_PERIOD = 2'd0,
      SEL_CH_A   = 2'd1,
      SEL_CH_B   = 2'd2,
      SEL_CH_C   = 2'd3
   } pwm3_sel_e;

   localparam int unsigned NUM_CH   = 3;
   localparam int unsigned LEAD_MIN = 2;
endpackage

// File: rtl/pwm3_cycle_ctr.sv
module pwm3_cycle_ctr #(
   parameter int unsigned W    = 12,
   parameter int unsigned LEAD = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] per_eff,
   output logic [W-1:0] cnt_q,
   output logic         wrap,
   output logic         commit,
   output logic         calc
);
   localparam logic [W-1:0] LEAD_V = W'(LEAD);

   logic calc_q;

   assign wrap   = (cnt_q >= per_eff - 1'b1);
   assign commit = (cnt_q == per_eff - LEAD_V);
   assign calc   = calc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         calc_q <= 1'b0;
      end else begin
         cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
         calc_q <= commit;
      end
   end
endmodule

// File: rtl/pwm3_chan.sv
module pwm3_chan #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         take,
   input  logic         calc,
   input  logic         wrap,
   input  logic [W-1:0] per_nx,
   input  logic [W-1:0] cnt,
   output logic         on,
   output logic [W-1:0] ontime
);
   logic [W-1:0] shadow_q, duty_nx_q;
   logic [W-1:0] lo_nx_q, hi_nx_q, eff_nx_q;
   logic [W-1:0] lo_q, hi_q, eff_q;
   logic [W-1:0] eff_c, lo_c;

   always_comb begin
      eff_c = (duty_nx_q >= per_nx) ? per_nx : duty_nx_q;
      lo_c  = (per_nx - eff_c) >> 1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow_q  <= '0;
         duty_nx_q <= '0;
         lo_nx_q   <= '0;
         hi_nx_q   <= '0;
         eff_nx_q  <= '0;
         lo_q      <= '0;
         hi_q      <= '0;
         eff_q     <= '0;
      end else begin
         if (wr)   shadow_q  <= wdata;
         if (take) duty_nx_q <= shadow_q;
         if (calc) begin
            lo_nx_q  <= lo_c;
            hi_nx_q  <= lo_c + eff_c;
            eff_nx_q <= eff_c;
         end
         if (wrap) begin
            lo_q  <= lo_nx_q;
            hi_q  <= hi_nx_q;
            eff_q <= eff_nx_q;
         end
      end
   end

   assign on     = (cnt >= lo_q) && (cnt < hi_q);
   assign ontime = eff_q;
endmodule

// File: rtl/pwm3_center_timer.sv
module pwm3_center_timer #(
   parameter int unsigned W          = 12,
   parameter int unsigned LEAD       = 4,
   parameter int unsigned MIN_PERIOD = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [W-1:0]         wr_data,
   output logic                 sync_o,
   output logic [2:0]           ch_on_o,
   output logic [3*W-1:0]       ch_ontime_o
);
   import pwm3_pkg::*;

   localparam logic [W-1:0] MIN_V = W'(MIN_PERIOD);

   if (LEAD < LEAD_MIN || MIN_PERIOD < LEAD + 2 || MIN_PERIOD >= (1 << W))
   begin : g_bad_cfg
      $error("pwm3_center_timer: LEAD or MIN_PERIOD out of range");
   end

   logic [W-1:0]      per_sh_q, per_nx_q, per_eff, cnt_q;
   logic              wrap, commit, calc, take;
   logic [NUM_CH-1:0] pend_q, ch_wr;

   pwm3_cycle_ctr #(.W(W), .LEAD(LEAD)) u_ctr (
      .clk(clk), .rst(rst), .per_eff(per_eff), .cnt_q(cnt_q),
      .wrap(wrap), .commit(commit), .calc(calc)
   );

   assign take = commit && (&pend_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         per_sh_q <= '0;
         per_nx_q <= MIN_V;
         per_eff  <= MIN_V;
      end else begin
         if (wr_en && wr_sel == SEL_PERIOD) per_sh_q <= wr_data;
         if (commit) per_nx_q <= (per_sh_q < MIN_V) ? MIN_V : per_sh_q;
         if (wrap)   per_eff  <= per_nx_q;
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign ch_wr[i] = wr_en && (wr_sel == 2'(i + 1));

      always_ff @(posedge clk) begin
         if (rst)           pend_q[i] <= 1'b0;
         else if (ch_wr[i]) pend_q[i] <= 1'b1;
         else if (take)     pend_q[i] <= 1'b0;
      end

      pwm3_chan #(.W(W)) u_chan (
         .clk(clk), .rst(rst), .wr(ch_wr[i]), .wdata(wr_data),
         .take(take), .calc(calc), .wrap(wrap), .per_nx(per_nx_q),
         .cnt(cnt_q), .on(ch_on_o[i]), .ontime(ch_ontime_o[i*W +: W])
      );
   end

   assign sync_o = (cnt_q == '0);
endmodule

// File: rtl/pwm3_center_timer_chk.sv
module pwm3_center_timer_chk #(
   parameter int unsigned W = 12
) (
   input logic           clk,
   input logic           rst,
   input logic           sync_o,
   input logic [2:0]     ch_on_o,
   input logic [3*W-1:0] ch_ontime_o,
   input logic [W-1:0]   cnt,
   input logic [W-1:0]   per_eff
);
   p_sync_one_clk_r8: assert property (@(posedge clk) disable iff (rst)
      sync_o |=> !sync_o);

   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
      cnt < per_eff);

   p_ontime_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !sync_o |-> $stable(ch_ontime_o));

   for (genvar i = 0; i < 3; i++) begin : g_p
      p_zero_off_r5: assert property (@(posedge clk) disable iff (rst)
         (ch_ontime_o[i*W +: W] == '0) |-> !ch_on_o[i]);
      p_full_on_r5: assert property (@(posedge clk) disable iff (rst)
         (ch_ontime_o[i*W +: W] == per_eff) |-> ch_on_o[i]);
      p_ontime_limit_r5: assert property (@(posedge clk) disable iff (rst)
         ch_ontime_o[i*W +: W] <= per_eff);
   end
endmodule

bind pwm3_center_timer pwm3_center_timer_chk #(.W(W)) u_chk (
   .clk(clk), .rst(rst), .sync_o(sync_o), .ch_on_o(ch_on_o),
   .ch_ontime_o(ch_ontime_o), .cnt(cnt_q), .per_eff(per_eff)
);

// File: tb/tb_pwm3_center_timer.sv
module tb_pwm3_center_timer;
   localparam int W = 12;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           wr_en = 1'b0;
   logic [1:0]     wr_sel = '0;
   logic [W-1:0]   wr_data = '0;
   logic           sync_o;
   logic [2:0]     ch_on_o;
   logic [3*W-1:0] ch_ontime_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   pwm3_center_timer dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .sync_o(sync_o), .ch_on_o(ch_on_o), .ch_ontime_o(ch_ontime_o)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_on(int p, int d, int k);
      int e = (d > p) ? p : d;
      int lo = (p - e) / 2;
      return (k >= lo) && (k < lo + e);
   endfunction

   task automatic wait_sync();
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sync_o && n < 5000);
      chk(sync_o, "R2 sync seen", sync_o, 1);
   endtask

   task automatic wr(input int sel, input int d);
      wr_en = 1'b1; wr_sel = 2'(sel); wr_data = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Called at the negedge where sync is high (k = 0); ends at the next one.
   task automatic verify(input int p, input int a, input int b, input int c, input string tag);
      int d[3];
      d[0] = a; d[1] = b; d[2] = c;
      for (int k = 0; k < p; k++) begin
         chk(sync_o == (k == 0), "R2/R8 sync position", sync_o, k == 0);
         for (int i = 0; i < 3; i++) begin
            bit e = exp_on(p, d[i], k);
            chk(ch_on_o[i] == e, {tag, " R4 channel on"}, ch_on_o[i], e);
            if (k == 0) begin
               int eo = (d[i] > p) ? p : d[i];
               chk(ch_ontime_o[i*W +: W] == W'(eo), {tag, " R5 ontime"},
                   ch_ontime_o[i*W +: W], eo);
            end
         end
         @(negedge clk);
      end
      chk(sync_o == 1'b1, "R2 cycle length", sync_o, 1);
   endtask

   task automatic prog(input int p, input int a, input int b, input int c, input string tag);
      int pe = (p < 8) ? 8 : p;
      wait_sync();
      wr_en = 1'b1; wr_sel = 2'd0; wr_data = W'(p); @(negedge clk);
      wr_sel = 2'd1; wr_data = W'(a); @(negedge clk);
      wr_sel = 2'd2; wr_data = W'(b); @(negedge clk);
      wr_sel = 2'd3; wr_data = W'(c); @(negedge clk);
      wr_en = 1'b0;
      wait_sync();
      verify(pe, a, b, c, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk(sync_o == 1'b1, "R1 sync after reset", sync_o, 1);
      chk(ch_on_o == 3'b000, "R1 outputs off", ch_on_o, 0);
      chk(ch_ontime_o == '0, "R1 ontime zero", ch_ontime_o, 0);
      begin
         int n = 0;
         do begin
            @(negedge clk);
            n++;
            chk(ch_on_o == 3'b000, "R1 outputs stay off", ch_on_o, 0);
         end while (!sync_o && n < 100);
         chk(n == 8, "R1 reset period", n, 8);
      end

      // R3/R4/R5: sweep with period 20 (even)
      for (int d = 0; d <= 22; d++)
         prog(20, d, (d * 7) % 23, 22 - d, "R3 sweep20");
      // R4: odd period 9
      for (int d = 0; d <= 10; d++)
         prog(9, d, 10 - d, (d * 3) % 11, "R4 sweep9");
      // R2: period below minimum is clamped to 8
      prog(3, 2, 8, 5, "R2 clamp");
      prog(20, 4, 6, 8, "R2 back to 20");

      // R6: partial writes do not take effect
      wait_sync();
      wr(1, 10);
      wr(2, 12);
      wait_sync();
      verify(20, 4, 6, 8, "R6 partial held");
      wr(3, 14);
      wait_sync();
      verify(20, 10, 12, 14, "R6 completed");

      // R7: last write at k = P-4 is held over one cycle
      wait_sync();
      repeat (14) @(negedge clk);
      wr(1, 2);
      wr(2, 3);
      wr(3, 5);
      wait_sync();
      verify(20, 10, 12, 14, "R7 late held");
      verify(20, 2, 3, 5, "R7 late applied");

      // R7: last write at k = P-5 takes effect next cycle
      wait_sync();
      repeat (13) @(negedge clk);
      wr(1, 16);
      wr(2, 18);
      wr(3, 20);
      wait_sync();
      verify(20, 16, 18, 20, "R7 boundary");

      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #1900000;
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule